// File: doc/BRIEF.md
# Target Burst Read Sequencer

This block runs the target side of the data phases of a 32-bit PCI burst read. A decoder outside the block raises a hit input during the address phase. From that point the sequencer owns DEVSEL#, TRDY# and the AD drive until the master ends the burst. On the local side it talks to a simple back-end through four signals: a ready level, a transfer strobe, a 32-bit read word and a transaction-active flag.

The back-end is one word ahead of the bus. Each strobe tells it to present the next word in that cycle, and the block keeps that word in a one-entry holding register. The holding register drives AD. TRDY# asserts only when the back-end has been ready for the two previous cycles and a word is held. Otherwise the block inserts wait states and AD keeps its value. When the master raises FRAME# for the final data phase and that phase completes, the block releases the bus in two steps. In the first cycle the control lines are driven high. In the next cycle they float. The word that was prefetched for the phase that never happens is discarded.

A parameter sets the DEVSEL# decode speed to fast, medium or slow. The default is slow.

Top module: `tbr_seq`

## Requirements
- R1: While rst_ni is low and after it is released, the block is idle. ad_oe_o, ctl_oe_o, be_active_o and be_xfer_o are 0, and devsel_n_o and trdy_n_o are 1.
- R2: If hit_i is high in cycle k while the block is idle, be_active_o is 1 from cycle k+1 until the end of the burst. If hit_i is high while a burst is active or being released, it has no effect.
- R3: If hit_i is high in idle cycle k, devsel_n_o goes low in cycle k+1+DEVSEL_DLY and stays low for the rest of the burst. DEVSEL_DLY is 0 for fast, 1 for medium and 2 for slow decode, and the default is 2.
- R4: ad_oe_o is 0 in cycle k+1, the turnaround cycle. ad_oe_o is 1 from the later of cycle k+2 and the first DEVSEL# cycle, through the last data phase.
- R5: be_xfer_o is 1 exactly when three things hold: the burst is active, be_rdy_i was 1 in the previous active cycle, and either the holding register is empty or a bus transfer (TRDY# and IRDY# both low) happens in the current cycle. On a strobe, be_data_i is captured.
- R6: trdy_n_o is low only when three things hold: be_rdy_i was 1 in each of the two preceding active cycles, a word is held, and the burst is not ending. Otherwise the block inserts a wait state and ad_o does not change.
- R7: On AD, the words appear in the order they were strobed. Each cycle with trdy_n_o and irdy_n_i both low consumes exactly one word.
- R8: The final data phase completes with TRDY# and IRDY# both low while FRAME# is high. In the cycle after it, devsel_n_o and trdy_n_o are driven high with ctl_oe_o set. In the same cycle ad_oe_o, be_active_o and be_xfer_o are 0.
- R9: One cycle after the step in R8, ctl_oe_o is 0 and the block is idle again.
- R10: If the back-end is ready in the cycle before the final transfer, the block strobes one word more than the number transferred on the bus.
- R11: trdy_n_o is never low while devsel_n_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_n_i | input | 1 | FRAME# from the master; high marks the final data phase |
| irdy_n_i | input | 1 | IRDY# from the master |
| hit_i | input | 1 | Address decode hit, high during the address phase |
| be_rdy_i | input | 1 | Back-end ready |
| be_data_i | input | DW | Read word presented by the back-end while be_xfer_o is high |
| be_xfer_o | output | 1 | Strobe that advances the back-end to the next word |
| be_active_o | output | 1 | Transaction active, to the back-end |
| ad_o | output | DW | Value driven on AD |
| ad_oe_o | output | 1 | AD output enable |
| devsel_n_o | output | 1 | DEVSEL# value |
| trdy_n_o | output | 1 | TRDY# value |
| ctl_oe_o | output | 1 | Output enable for DEVSEL# and TRDY# |

## Verification
Call the hit cycle k. be_active_o is due in k+1, DEVSEL# in k+1+DEVSEL_DLY and the AD enable no earlier than k+2. TRDY# follows the ready input and the held word by one register, and be_xfer_o reacts to IRDY# in the same cycle. The release steps come one and two cycles after the final transfer. The bench drives its inputs one time unit after each rising edge. On the following falling edge it compares every output against a behavioural model, which keeps a queue of prefetched words and is advanced just after each rising edge. On every completed transfer it also scores the AD word against the expected sequence, and after each burst it counts the strobes.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_REL} tbr_state_e;
  localparam int unsigned DEVSEL_FAST = 0;
  localparam int unsigned DEVSEL_MED  = 1;
  localparam int unsigned DEVSEL_SLOW = 2;
endpackage

// File: rtl/tbr_devsel_timer.sv
module tbr_devsel_timer #(
  parameter int unsigned DLY = tbr_pkg::DEVSEL_SLOW
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic clear_i,
  output logic on_d_o,
  output logic on_o
);
  localparam int unsigned CW = (DLY < 2) ? 1 : $clog2(DLY + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d, on_q, on_d;

  always_comb begin
    on_d   = on_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (clear_i) begin
      on_d   = 1'b0;
      pend_d = 1'b0;
    end else if (start_i) begin
      if (DLY == 0) on_d = 1'b1;
      else begin
        pend_d = 1'b1;
        cnt_d  = CW'(DLY - 1);
      end
    end else if (pend_q) begin
      if (cnt_q == '0) begin
        on_d   = 1'b1;
        pend_d = 1'b0;
      end else cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      on_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      on_q   <= on_d;
    end
  end

  assign on_d_o = on_d;
  assign on_o   = on_q;

  // R3: assertion happens exactly DLY+1 edges after the start pulse
  p_devsel_delay_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(on_q) |-> $past(start_i, DLY + 1));
endmodule

// File: rtl/tbr_prefetch.sv
module tbr_prefetch #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic          end_i,
  input  logic          rdy_i,
  input  logic          irdy_n_i,
  input  logic [DW-1:0] data_i,
  output logic          xfer_o,
  output logic          done_o,
  output logic          trdy_n_o,
  output logic [DW-1:0] ad_o
);
  logic          rdy1_q, hv_q, hv_d, trdy_q;
  logic [DW-1:0] hold_q;
  logic          done, xfer;

  assign done = trdy_q & ~irdy_n_i;
  // fetch when the slot is free or is being emptied this cycle
  assign xfer = act_i & rdy1_q & (~hv_q | done);
  assign hv_d = end_i ? 1'b0 : (xfer | (hv_q & ~done));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy1_q <= 1'b0;
      hv_q   <= 1'b0;
      trdy_q <= 1'b0;
      hold_q <= '0;
    end else begin
      rdy1_q <= act_i & rdy_i;
      hv_q   <= hv_d;
      trdy_q <= act_i & ~end_i & rdy_i & rdy1_q & hv_d;
      if (xfer) hold_q <= data_i;
    end
  end

  assign xfer_o   = xfer;
  assign done_o   = done;
  assign trdy_n_o = ~trdy_q;
  assign ad_o     = hold_q;

  p_trdy_hist_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trdy_n_o |-> ($past(act_i && rdy_i, 1) && $past(act_i && rdy_i, 2)));
  p_ad_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trdy_q && irdy_n_i && act_i) |=> $stable(ad_o));
  p_xfer_act_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> act_i);
endmodule

// File: rtl/tbr_seq.sv
module tbr_seq #(
  parameter int unsigned DW         = 32,
  parameter int unsigned DEVSEL_DLY = tbr_pkg::DEVSEL_SLOW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_n_i,
  input  logic          irdy_n_i,
  input  logic          hit_i,
  input  logic          be_rdy_i,
  input  logic [DW-1:0] be_data_i,
  output logic          be_xfer_o,
  output logic          be_active_o,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic          devsel_n_o,
  output logic          trdy_n_o,
  output logic          ctl_oe_o
);
  import tbr_pkg::*;

  tbr_state_e st_q, st_d;
  logic       start, end_now, act, done;
  logic       dev_on, dev_on_d, ad_oe_q;

  assign act     = (st_q == ST_ACT);
  assign start   = (st_q == ST_IDLE) & hit_i;
  assign end_now = act & done & frame_n_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start)   st_d = ST_ACT;
      ST_ACT:  if (end_now) st_d = ST_REL;
      ST_REL:               st_d = ST_IDLE;
      default:              st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ad_oe_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      // act already set implies the turnaround cycle has passed
      ad_oe_q <= act & ~end_now & dev_on_d;
    end
  end

  tbr_devsel_timer #(.DLY(DEVSEL_DLY)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .clear_i(end_now),
    .on_d_o (dev_on_d),
    .on_o   (dev_on)
  );

  tbr_prefetch #(.DW(DW)) i_prefetch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .act_i   (act),
    .end_i   (end_now),
    .rdy_i   (be_rdy_i),
    .irdy_n_i(irdy_n_i),
    .data_i  (be_data_i),
    .xfer_o  (be_xfer_o),
    .done_o  (done),
    .trdy_n_o(trdy_n_o),
    .ad_o    (ad_o)
  );

  assign be_active_o = act;
  assign ad_oe_o     = ad_oe_q;
  assign devsel_n_o  = ~dev_on;
  assign ctl_oe_o    = dev_on | (st_q == ST_REL);

  p_active_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && hit_i) |=> be_active_o);
  p_turnaround_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!be_active_o && !ctl_oe_o && hit_i) |=> !ad_oe_o);
  p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (be_active_o && !trdy_n_o && !irdy_n_i && frame_n_i) |=>
      (devsel_n_o && trdy_n_o && ctl_oe_o && !ad_oe_o && !be_active_o && !be_xfer_o));
  p_float_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_oe_o && devsel_n_o && !be_active_o) |=> !ctl_oe_o);
  p_trdy_devsel_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trdy_n_o |-> !devsel_n_o);
endmodule

// File: tb/test_tbr_seq.sv
module test_tbr_seq;
  localparam int          DLY   = 2;
  localparam logic [31:0] WBASE = 32'hC0DE_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_n_i = 1'b1, irdy_n_i = 1'b1, hit_i = 1'b0, be_rdy_i = 1'b0;
  logic [31:0] be_data_i;
  logic        be_xfer_o, be_active_o, ad_oe_o, devsel_n_o, trdy_n_o, ctl_oe_o;
  logic [31:0] ad_o;

  always #4 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  int be_cnt = 0;
  assign be_data_i = WBASE + be_cnt;

  tbr_seq i_tbr_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i),
    .hit_i(hit_i), .be_rdy_i(be_rdy_i), .be_data_i(be_data_i),
    .be_xfer_o(be_xfer_o), .be_active_o(be_active_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .devsel_n_o(devsel_n_o), .trdy_n_o(trdy_n_o), .ctl_oe_o(ctl_oe_o)
  );

  // behavioural model
  int          m_ph = 0, m_cyc = 0, done_cnt = 0;
  bit          m_r1 = 0, m_trdy = 0, sv_done = 0, sv_x = 0, xs = 0;
  logic [31:0] m_q[$];
  logic [31:0] burst_base;

  task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, a, e);
    end
  endtask

  task automatic cyc_check();
    bit m_dev, m_done, m_x;
    m_dev  = (m_ph == 1) && (m_cyc >= 1 + DLY);
    m_done = m_trdy && !irdy_n_i;
    m_x    = (m_ph == 1) && m_r1 && ((m_q.size() == 0) || m_done);
    chk(devsel_n_o == !m_dev, "R3 devsel_n", 32'(devsel_n_o), 32'(!m_dev));
    chk(trdy_n_o == !m_trdy, "R6 trdy_n", 32'(trdy_n_o), 32'(!m_trdy));
    chk(ctl_oe_o == (m_dev || m_ph == 2), "R9 ctl_oe", 32'(ctl_oe_o), 32'(m_dev || m_ph == 2));
    chk(be_active_o == (m_ph == 1), "R2 be_active", 32'(be_active_o), 32'(m_ph == 1));
    chk(be_xfer_o == m_x, "R5 be_xfer", 32'(be_xfer_o), 32'(m_x));
    chk(ad_oe_o == (m_dev && m_cyc >= 2), "R4 ad_oe", 32'(ad_oe_o), 32'(m_dev && m_cyc >= 2));
    if (m_ph == 2)
      chk(devsel_n_o && trdy_n_o && !ad_oe_o, "R8 release step", {devsel_n_o, trdy_n_o, ad_oe_o}, 3'b110);
    if (!trdy_n_o) chk(!devsel_n_o, "R11 trdy without devsel", 32'(devsel_n_o), 32'd0);
    if (m_done && m_q.size() > 0) begin
      chk(ad_o == m_q[0], "R7 ad word", ad_o, m_q[0]);
      chk(ad_o == burst_base + done_cnt, "R7 ad order", ad_o, burst_base + done_cnt);
    end
    if (!trdy_n_o && !irdy_n_i) done_cnt++;
    xs = be_xfer_o; sv_done = m_done; sv_x = m_x;
  endtask

  task automatic model_edge();
    bit end_now;
    end_now = (m_ph == 1) && sv_done && frame_n_i;
    if (sv_done && m_q.size() > 0) void'(m_q.pop_front());
    if (sv_x) m_q.push_back(WBASE + be_cnt);
    if (xs) be_cnt++;
    case (m_ph)
      0: if (hit_i) begin m_ph = 1; m_cyc = 1; m_r1 = 0; m_trdy = 0; end
      1: if (end_now) begin
           m_ph = 2; m_q.delete(); m_trdy = 0; m_r1 = 0;
         end else begin
           m_trdy = be_rdy_i && m_r1 && (m_q.size() > 0);
           m_r1   = be_rdy_i;
           m_cyc++;
         end
      default: m_ph = 0;
    endcase
  endtask

  task automatic tick();
    @(negedge clk_i);
    cyc_check();
    @(posedge clk_i);
    #1;
    model_edge();
  endtask

  task automatic burst(input int n, input logic [31:0] rpat, input logic [31:0] ipat,
                       input int stray, input bit chk_extra);
    int start_cnt;
    start_cnt  = be_cnt;
    burst_base = WBASE + be_cnt;
    done_cnt   = 0;
    hit_i = 1'b1; frame_n_i = 1'b0; irdy_n_i = 1'b1; be_rdy_i = 1'b0;
    tick();
    for (int c = 1; c < 200 && done_cnt < n; c++) begin
      hit_i     = (c == stray);  // R2: stray hit mid-burst is ignored
      frame_n_i = (done_cnt == n - 1);
      irdy_n_i  = frame_n_i ? 1'b0 : !ipat[c % 32];
      be_rdy_i  = rpat[c % 32];
      tick();
    end
    hit_i = 1'b0; frame_n_i = 1'b1; irdy_n_i = 1'b1; be_rdy_i = 1'b0;
    repeat (3) tick();
    chk(done_cnt == n, "R7 transfer count", done_cnt, n);
    chk(!ctl_oe_o && !ad_oe_o, "R9 bus floated", {ctl_oe_o, ad_oe_o}, 2'b00);
    if (chk_extra) chk(be_cnt - start_cnt == n + 1, "R10 one extra strobe", be_cnt - start_cnt, n + 1);
  endtask

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1: outputs during reset
    chk(!ctl_oe_o && !ad_oe_o && !be_active_o && !be_xfer_o && devsel_n_o && trdy_n_o,
        "R1 reset state", {ctl_oe_o, ad_oe_o, be_active_o, be_xfer_o, devsel_n_o, trdy_n_o}, 6'b000011);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    repeat (2) tick();
    chk(!ctl_oe_o && devsel_n_o && trdy_n_o, "R1 idle after reset",
        {ctl_oe_o, devsel_n_o, trdy_n_o}, 3'b011);
    burst(4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, -1, 1'b1);
    burst(6, 32'hFFFF_F6DE, 32'hFFFF_FB77, 5, 1'b0);
    burst(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, -1, 1'b1);
    burst(5, 32'hEEEE_EEEE, 32'hFFFF_FFFF, 2, 1'b0);
    burst(8, 32'hFFFF_FFFF, 32'hDDDD_DDDD, -1, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule